// File: doc/BRIEF.md
# Serial Command Slave with Write-Protect Latch

This block is the serial-port front end of a power-management controller. An external host selects it with an active-low chip select and clocks one-byte instruction codes into it, most significant bit first. The block keeps a 16-bit control word and drives it onto a parallel port for the regulators and switches. It can return that control word or an 8-bit diagnostic byte taken from a parallel input. The control word can only be changed after a separate enable instruction has armed a protection latch, and each completed write disarms that latch again.

The serial pins are sampled with the block's own system clock through a synchronizer. Input bits are taken on rising serial-clock edges and output bits change after falling edges. Because of this, a host running with the clock idling low (mode 0) or idling high (mode 3) is served without any setting. The data output has a separate enable. It stays inactive whenever the block is deselected, so several slaves can share one data line.

Top module: `spicmd_slave`

## Requirements
- R1: While reset is active, and right after it, the control output is 0, the data-output enable is 0 and the protection latch is clear.
- R2: Bits on the data input are taken on rising serial-clock edges, MSB first. The first rising edge after chip select falls is opcode bit 7. Mode 0 and mode 3 hosts both work.
- R3: After the enable opcode 0x06, a frame with opcode 0x02 followed by exactly 16 data bits (s15 first) loads those bits into the control output when chip select rises.
- R4: A write frame (0x02) sent while the latch is clear leaves the control output unchanged. The latch is clear after reset.
- R5: A committed write clears the latch, so a second write frame without a fresh 0x06 is discarded.
- R6: Opcode 0x04 clears the latch, and a following write frame is discarded.
- R7: A write frame with fewer or more than 16 data bits before deselect is discarded and leaves the latch as it was.
- R8: Opcode 0x03 returns the 16-bit control word MSB first. Each bit is valid from the falling edge after the previous rising edge, starting at the falling edge after the eighth opcode bit.
- R9: Opcode 0x05 returns the diagnostic input byte, captured when the opcode completes, MSB first. Bits clocked past the end of a read are 0.
- R10: An opcode outside {0x02, 0x03, 0x04, 0x05, 0x06} changes neither the control word nor the latch. The rest of its frame is ignored.
- R11: After 0x06 or 0x04, further bits in the same frame are ignored until deselect.
- R12: The data-output enable is 1 while selected and drops shortly after chip select rises. A deselect aborts a read, and the next read starts afresh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; samples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk | input | 1 | Serial clock from the host |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial data to the host |
| spi_miso_oe | output | 1 | Drive enable for spi_miso (0 = high impedance) |
| diag_i | input | 8 | Diagnostic byte returned by opcode 0x05 |
| ctrl_o | output | 16 | Control word held by the block |

## Verification
The hardest case to bring about is a frame that looks valid but must be rejected. Examples are a write that follows a disable in an earlier frame, a write one bit short or one bit long, and a disable opcode clocked into the same frame right after an enable. The stimulus builds these from an ordinary host task whose bit count and payload are free. It then proves the latch state through the ports by sending a well-formed write and checking whether it commits. The read paths are driven in both clock polarities, including a read cut off part-way.

// File: rtl/spicmd_pkg.sv
package spicmd_pkg;
   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_OPC   = 3'd1,
      ST_WDATA = 3'd2,
      ST_READ  = 3'd3,
      ST_HOLD  = 3'd4
   } spi_st_e;
endpackage

// File: rtl/spicmd_sync.sv
module spicmd_sync #(
   parameter int         WIDTH   = 3,
   parameter int         STAGES  = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] async_i,
   output logic [WIDTH-1:0] sync_o
);
   generate
      if (STAGES < 1) begin : g_bad
         $error("spicmd_sync: STAGES must be at least 1");
      end
   endgenerate

   logic [WIDTH-1:0] chain [STAGES];

   generate
      for (genvar k = 0; k < STAGES; k++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[k] <= RST_VAL;
            else if (k == 0) chain[k] <= async_i;
            else chain[k] <= chain[(k == 0) ? 0 : k-1];
         end
      end
   endgenerate

   assign sync_o = chain[STAGES-1];
endmodule

// File: rtl/spicmd_decoder.sv
module spicmd_decoder
   import spicmd_pkg::*;
#(
   parameter int              OPC_W   = 8,
   parameter int              STAT_W  = 16,
   parameter logic [OPC_W-1:0] OP_WREN = 8'h06,
   parameter logic [OPC_W-1:0] OP_WRDI = 8'h04,
   parameter logic [OPC_W-1:0] OP_WRST = 8'h02,
   parameter logic [OPC_W-1:0] OP_RDST = 8'h03,
   parameter logic [OPC_W-1:0] OP_RDDG = 8'h05
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sel,
   input  logic              rise,
   input  logic              din,
   output spi_st_e           st_o,
   output logic              wel_o,
   output logic [STAT_W-1:0] ctrl_o,
   output logic              ld_stat_o,
   output logic              ld_diag_o
);
   localparam int OCNT_W = $clog2(OPC_W);
   localparam int DCNT_W = $clog2(STAT_W + 2);
   localparam logic [OCNT_W-1:0] OCNT_LAST = OCNT_W'(OPC_W - 1);
   localparam logic [DCNT_W-1:0] DCNT_FULL = DCNT_W'(STAT_W);
   localparam logic [DCNT_W-1:0] DCNT_OVER = DCNT_W'(STAT_W + 1);

   generate
      if (OPC_W < 2 || STAT_W < 2) begin : g_bad
         $error("spicmd_decoder: OPC_W and STAT_W must be at least 2");
      end
   endgenerate

   spi_st_e           st;
   logic              wel;
   logic [STAT_W-1:0] ctrl_q;
   logic [STAT_W-1:0] dsh;
   logic [OPC_W-1:0]  opc_sh;
   logic [OPC_W-1:0]  opc_nx;
   logic [OCNT_W-1:0] ocnt;
   logic [DCNT_W-1:0] dcnt;

   assign opc_nx = {opc_sh[OPC_W-2:0], din};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= ST_IDLE;
         wel       <= 1'b0;
         ctrl_q    <= '0;
         dsh       <= '0;
         opc_sh    <= '0;
         ocnt      <= '0;
         dcnt      <= '0;
         ld_stat_o <= 1'b0;
         ld_diag_o <= 1'b0;
      end else begin
         ld_stat_o <= 1'b0;
         ld_diag_o <= 1'b0;
         if (!sel) begin
            if (st == ST_WDATA && dcnt == DCNT_FULL) begin
               ctrl_q <= dsh;
               wel    <= 1'b0;
            end
            st   <= ST_IDLE;
            ocnt <= '0;
            dcnt <= '0;
         end else begin
            unique case (st)
               ST_IDLE: st <= ST_OPC;
               ST_OPC: begin
                  if (rise) begin
                     opc_sh <= opc_nx;
                     ocnt   <= ocnt + 1'b1;
                     if (ocnt == OCNT_LAST) begin
                        if (opc_nx == OP_WREN) begin
                           wel <= 1'b1;
                           st  <= ST_HOLD;
                        end else if (opc_nx == OP_WRDI) begin
                           wel <= 1'b0;
                           st  <= ST_HOLD;
                        end else if (opc_nx == OP_WRST) begin
                           st <= wel ? ST_WDATA : ST_HOLD;
                        end else if (opc_nx == OP_RDST) begin
                           ld_stat_o <= 1'b1;
                           st        <= ST_READ;
                        end else if (opc_nx == OP_RDDG) begin
                           ld_diag_o <= 1'b1;
                           st        <= ST_READ;
                        end else begin
                           st <= ST_HOLD;
                        end
                     end
                  end
               end
               ST_WDATA: begin
                  if (rise) begin
                     dsh <= {dsh[STAT_W-2:0], din};
                     if (dcnt != DCNT_OVER) dcnt <= dcnt + 1'b1;
                  end
               end
               default: ;
            endcase
         end
      end
   end

   assign st_o   = st;
   assign wel_o  = wel;
   assign ctrl_o = ctrl_q;
endmodule

// File: rtl/spicmd_shifter.sv
module spicmd_shifter #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         sel,
   input  logic         fall,
   input  logic         load,
   input  logic [W-1:0] load_val,
   output logic         miso_o,
   output logic         oe_o
);
   logic [W-1:0] sh;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh     <= '0;
         miso_o <= 1'b0;
         oe_o   <= 1'b0;
      end else begin
         oe_o <= sel;
         if (!sel) begin
            sh     <= '0;
            miso_o <= 1'b0;
         end else if (load) begin
            sh <= load_val;
         end else if (fall) begin
            miso_o <= sh[W-1];
            sh     <= {sh[W-2:0], 1'b0};
         end
      end
   end
endmodule

// File: rtl/spicmd_slave.sv
module spicmd_slave
   import spicmd_pkg::*;
#(
   parameter int OPC_W       = 8,
   parameter int STAT_W      = 16,
   parameter int DIAG_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              spi_sclk,
   input  logic              spi_cs_n,
   input  logic              spi_mosi,
   output logic              spi_miso,
   output logic              spi_miso_oe,
   input  logic [DIAG_W-1:0] diag_i,
   output logic [STAT_W-1:0] ctrl_o
);
   localparam int PAD_W = STAT_W - DIAG_W;

   generate
      if (DIAG_W < 1 || STAT_W < DIAG_W) begin : g_bad
         $error("spicmd_slave: need 1 <= DIAG_W <= STAT_W");
      end
   endgenerate

   logic [2:0]        pins_s;
   logic              sclk_s, cs_s, mosi_s, sclk_d;
   logic              sel, rise, fall;
   spi_st_e           st;
   logic              wel;
   logic [STAT_W-1:0] ctrl_q;
   logic              ld_stat, ld_diag;
   logic [STAT_W-1:0] diag_al;
   logic [STAT_W-1:0] load_val;

   spicmd_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) i_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .async_i ({spi_mosi, spi_cs_n, spi_sclk}),
      .sync_o  (pins_s)
   );

   assign sclk_s = pins_s[0];
   assign cs_s   = pins_s[1];
   assign mosi_s = pins_s[2];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sclk_d <= 1'b0;
      else sclk_d <= sclk_s;
   end

   assign sel  = ~cs_s;
   assign rise = sclk_s & ~sclk_d;
   assign fall = ~sclk_s & sclk_d;

   spicmd_decoder #(.OPC_W(OPC_W), .STAT_W(STAT_W)) i_dec (
      .clk       (clk),
      .rst_n     (rst_n),
      .sel       (sel),
      .rise      (rise),
      .din       (mosi_s),
      .st_o      (st),
      .wel_o     (wel),
      .ctrl_o    (ctrl_q),
      .ld_stat_o (ld_stat),
      .ld_diag_o (ld_diag)
   );

   generate
      if (PAD_W == 0) begin : g_diag_full
         assign diag_al = diag_i;
      end else begin : g_diag_pad
         assign diag_al = {diag_i, {PAD_W{1'b0}}};
      end
   endgenerate

   assign load_val = ld_diag ? diag_al : ctrl_q;

   spicmd_shifter #(.W(STAT_W)) i_shift (
      .clk      (clk),
      .rst_n    (rst_n),
      .sel      (sel),
      .fall     (fall),
      .load     (ld_stat | ld_diag),
      .load_val (load_val),
      .miso_o   (spi_miso),
      .oe_o     (spi_miso_oe)
   );

   assign ctrl_o = ctrl_q;
endmodule

// File: rtl/spicmd_slave_chk.sv
module spicmd_slave_chk
   import spicmd_pkg::*;
#(
   parameter int STAT_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input spi_st_e           st,
   input logic              wel,
   input logic [STAT_W-1:0] ctrl_q,
   input logic              miso_oe
);
   p_ctrl_from_wdata_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(ctrl_q) |-> $past(st) == ST_WDATA);

   p_wdata_needs_wel_r4: assert property (@(posedge clk) disable iff (!rst_n)
      st == ST_WDATA |-> wel);

   p_commit_clears_wel_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(ctrl_q) |-> $fell(wel));

   p_wel_set_by_opcode_r11: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wel) |-> $past(st) == ST_OPC);

   p_hold_until_deselect_r11: assert property (@(posedge clk) disable iff (!rst_n)
      st == ST_HOLD |=> (st == ST_HOLD || st == ST_IDLE));

   p_hiz_when_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
      st == ST_IDLE |-> !miso_oe);
endmodule

bind spicmd_slave spicmd_slave_chk #(.STAT_W(STAT_W)) i_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .st      (st),
   .wel     (wel),
   .ctrl_q  (ctrl_q),
   .miso_oe (spi_miso_oe)
);

// File: tb/test_spicmd_slave.sv
`timescale 1ns/1ps
module test_spicmd_slave;
   localparam int HALF = 80;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
   logic        miso, miso_oe;
   logic [7:0]  diag = 8'h00;
   logic [15:0] ctrl;

   int n_chk = 0, n_fail = 0;
   bit done = 0;

   logic [15:0] exp_q[$];
   logic [15:0] got_q[$];
   string       tag_q[$];

   always #5 clk = ~clk;

   spicmd_slave i_spicmd_slave (
      .clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_cs_n(cs_n),
      .spi_mosi(mosi), .spi_miso(miso), .spi_miso_oe(miso_oe),
      .diag_i(diag), .ctrl_o(ctrl)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic xfer(input bit m3, input int nb, input logic [39:0] tx,
                       output logic [39:0] rx, output bit oe_ok);
      rx = '0;
      oe_ok = 1;
      sclk = m3;
      #(2*HALF);
      cs_n = 1'b0;
      #(2*HALF);
      for (int i = nb - 1; i >= 0; i--) begin
         if (m3) begin
            sclk = 1'b0;
            mosi = tx[i];
            #HALF;
            rx = {rx[38:0], miso};
            oe_ok &= (miso_oe === 1'b1);
            sclk = 1'b1;
            #HALF;
         end else begin
            mosi = tx[i];
            #HALF;
            rx = {rx[38:0], miso};
            oe_ok &= (miso_oe === 1'b1);
            sclk = 1'b1;
            #HALF;
            sclk = 1'b0;
         end
      end
      #HALF;
      cs_n = 1'b1;
      #(4*HALF);
   endtask

   task automatic send(input bit m3, input int nb, input logic [39:0] tx);
      logic [39:0] rx;
      bit ok;
      xfer(m3, nb, tx, rx, ok);
   endtask

   task automatic wren(input bit m3);
      send(m3, 8, 40'h06);
   endtask

   task automatic wrst(input bit m3, input logic [15:0] v);
      send(m3, 24, {16'h0, 8'h02, v});
   endtask

   // driver: push expectation, run read, hand captured value to monitor
   task automatic rd(input bit m3, input logic [7:0] op, input int nd,
                     input logic [15:0] exp, input string tag);
      logic [39:0] rx;
      bit ok;
      exp_q.push_back(exp);
      tag_q.push_back(tag);
      xfer(m3, 8 + nd, {32'h0, op} << nd, rx, ok);
      got_q.push_back(rx[15:0]);
      check({tag, " oe while selected"}, ok, 1'b1);
   endtask

   // monitor
   initial begin
      forever begin
         @(negedge clk);
         if (got_q.size() > 0 && exp_q.size() > 0)
            check(tag_q.pop_front(), got_q.pop_front(), exp_q.pop_front());
      end
   end

   initial begin
      #2000000;
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      logic [39:0] rx;
      bit ok;
      repeat (4) @(negedge clk);
      check("R1 ctrl in reset", ctrl, 16'h0);
      check("R1 oe in reset", miso_oe, 1'b0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      check("R1 ctrl after reset", ctrl, 16'h0);

      wrst(0, 16'hA5C3);
      check("R4 write with latch clear", ctrl, 16'h0);

      wren(0);
      wrst(0, 16'hA5C3);
      check("R3 mode0 write commits", ctrl, 16'hA5C3);

      wrst(0, 16'h1234);
      check("R5 second write needs enable", ctrl, 16'hA5C3);

      rd(0, 8'h03, 16, 16'hA5C3, "R8 mode0 status read");
      check("R12 oe after deselect", miso_oe, 1'b0);

      wren(1);
      wrst(1, 16'h5AF0);
      check("R2 mode3 write commits", ctrl, 16'h5AF0);
      rd(1, 8'h03, 16, 16'h5AF0, "R8 mode3 status read");

      wren(0);
      send(0, 8, 40'h04);
      wrst(0, 16'h0F0F);
      check("R6 disable blocks write", ctrl, 16'h5AF0);

      wren(0);
      send(0, 23, {17'h0, 8'h02, 15'h7FFF});
      check("R7 short write dropped", ctrl, 16'h5AF0);
      send(0, 25, {15'h0, 8'h02, 17'h1FFFF});
      check("R7 long write dropped", ctrl, 16'h5AF0);
      wrst(0, 16'h3C3C);
      check("R7 latch kept over partial frames", ctrl, 16'h3C3C);

      wren(0);
      send(0, 24, {16'h0, 8'hA7, 16'hFFFF});
      check("R10 unknown opcode no change", ctrl, 16'h3C3C);
      wrst(0, 16'h8001);
      check("R10 latch kept over unknown opcode", ctrl, 16'h8001);

      send(0, 24, {16'h0, 8'h06, 8'h04, 8'h00});
      wrst(0, 16'h7E7E);
      check("R11 bits after enable ignored", ctrl, 16'h7E7E);
      send(1, 24, {16'h0, 8'h04, 8'h06, 8'h00});
      wrst(1, 16'h1111);
      check("R11 bits after disable ignored", ctrl, 16'h7E7E);

      diag = 8'hB6;
      rd(0, 8'h05, 8, {8'h00, 8'hB6}, "R9 mode0 diag read");
      rd(0, 8'h05, 16, {8'hB6, 8'h00}, "R9 diag trailing zeros");
      diag = 8'h49;
      rd(1, 8'h05, 8, {8'h00, 8'h49}, "R9 mode3 diag read");

      xfer(0, 12, {28'h0, 8'h03, 4'h0}, rx, ok);
      check("R12 aborted read bits", rx[3:0], 4'h7);
      check("R12 oe after abort", miso_oe, 1'b0);
      rd(0, 8'h03, 16, 16'h7E7E, "R12 read after abort");

      repeat (10) @(negedge clk);
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule